// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in memory. A root pointer register gives the page that holds the first-level table. The walker reads one first-level entry, which points to a second-level table. It then reads one second-level entry, which supplies the physical frame. The frame is joined with the 12-bit page offset to form the result. Each table holds 1024 entries of 4 bytes each, so every table fills exactly one 4 KiB page.

A client sends one translation request at a time, together with an access type (read or write). Some cycles later the client receives one response. The response carries either the physical address or a fault. A fault reports the level that failed and whether the cause was a missing entry or a missing permission. Table reads go out on a simple memory read port. That port uses a valid/ready request and a single-beat response that may arrive after any number of cycles.

The operating system reloads the root pointer on a context switch. If that write lands while a walk is running, the walker holds it back until the walk has ended.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first table read goes to the address made from the root pointer with its low 12 bits cleared, plus four times the virtual address bits [31:22]. The low 12 bits of the written root value are ignored.
- R3: The second table read goes to the address made from bits [31:12] of the first-level entry (as a 4 KiB frame) combined with four times the virtual address bits [21:12].
- R4: A memory request keeps its address until it is accepted. Only one read is outstanding at a time. `req_ready` stays 0 from the moment a request is accepted until its response has been given.
- R5: When the walk succeeds, `rsp_fault` is 0 and `rsp_paddr` is the second-level entry bits [31:12] followed by the virtual address bits [11:0].
- R6: A first-level entry with bit 0 (valid) clear ends the walk after one read. The response then has `rsp_fault`=1, `rsp_fault_level`=0 (first level) and `rsp_fault_perm`=0 (invalid entry). Bits 1 and 2 of a first-level entry have no effect.
- R7: A second-level entry with bit 0 clear gives `rsp_fault`=1, `rsp_fault_level`=1 and `rsp_fault_perm`=0.
- R8: For a valid second-level entry, a read needs bit 1 (readable) set and a write needs bit 2 (writable) set. If the needed bit is clear, the response has `rsp_fault`=1, `rsp_fault_level`=1 and `rsp_fault_perm`=1.
- R9: `rsp_valid` is high for exactly one cycle, in the cycle after the last table data arrives. Unless a root write is waiting, `req_ready` is 1 again in the next cycle.
- R10: A write to the root pointer made while the walker is idle affects the next walk. A write made during a walk leaves that walk's addresses unchanged. If several such writes occur, the last one wins. It is applied in the first cycle after the response, and `req_ready` is 0 during that cycle.
- R11: On any fault, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_wr_en | input | 1 | Root pointer write strobe |
| root_wr_data | input | 32 | New root pointer value (low 12 bits ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_level | output | 1 | 0 = first level, 1 = second level |
| rsp_fault_perm | output | 1 | 1 = permission fault, 0 = invalid entry |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid (single beat) |
| mem_rsp_data | input | 32 | Table entry read from memory |

## Verification
The assertions assume that the memory side behaves well. It answers each accepted read with exactly one `mem_rsp_valid` beat, and it never sends a beat when no read is outstanding. They also assume that the client holds `req_valid` and the request fields until the request is accepted. The bench meets both assumptions by design. Its memory model starts a single countdown for each accepted read and returns one beat when the countdown ends. Its ready signal and latency vary with a free-running counter. Its request task drives and releases its inputs only on falling edges, and it waits for acceptance before releasing them.

// File: rtl/ptw_pkg.sv
// Package: shared types and entry bit positions for the page table walker.
// Assumes table entries are as wide as a physical address.
package ptw_pkg;

    // Bit positions of the flag bits inside a table entry
    localparam int unsigned PTE_VALID_BIT = 0;
    localparam int unsigned PTE_READ_BIT  = 1;
    localparam int unsigned PTE_WRITE_BIT = 2;
    localparam int unsigned PTE_FLAG_W    = 3;

    // Walker control states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_RESP    = 3'd5
    } walk_state_t;

endpackage

// File: rtl/ptw_root_reg.sv
// Root pointer register with deferral.
// A write while the walker is idle lands at once. A write while it is busy
// is parked in a shadow register and applied on the first idle cycle.
// Assumes busy is high from acceptance through the response cycle.
module ptw_root_reg #(
    parameter int unsigned PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    input  logic            busy,
    output logic [PA_W-1:0] root_base,
    output logic            pending
);

    logic [PA_W-1:0] root_q;
    logic [PA_W-1:0] shadow_q;
    logic            shadow_v_q;

    // Live root pointer: direct write when idle, shadow drain after a walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q <= '0;
        end else if (wr_en && !busy) begin
            root_q <= wr_data;
        end else if (!busy && shadow_v_q) begin
            root_q <= shadow_q;
        end
    end

    // Shadow holding the latest write made during a walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q   <= '0;
            shadow_v_q <= 1'b0;
        end else if (wr_en && busy) begin
            shadow_q   <= wr_data;
            shadow_v_q <= 1'b1;
        end else if (!busy) begin
            shadow_v_q <= 1'b0;
        end
    end

    assign root_base = root_q;
    assign pending   = shadow_v_q;

endmodule

// File: rtl/ptw_addr_gen.sv
// Table entry address generator.
// Picks the first-level or second-level table base and adds the scaled
// index taken from the virtual page number. Purely combinational.
// Assumes table bases are page aligned once their offset bits are masked.
module ptw_addr_gen #(
    parameter int unsigned PA_W    = 32,
    parameter int unsigned L1_W    = 10,
    parameter int unsigned L2_W    = 10,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned ENTRY_B = 4
) (
    input  logic [L1_W+L2_W-1:0] vpn,
    input  logic [PA_W-1:0]      root_base,
    input  logic [PA_W-1:0]      l2_base,
    input  logic                 sel_l2,
    output logic [PA_W-1:0]      entry_addr
);

    localparam int unsigned SHIFT = $clog2(ENTRY_B);
    localparam logic [PA_W-1:0] PAGE_MASK = {{(PA_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

    logic [L1_W-1:0] idx_hi;
    logic [L2_W-1:0] idx_lo;
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] scaled;

    // Select table base and scaled index for the current level
    always_comb begin
        idx_hi     = vpn[L1_W+L2_W-1:L2_W];
        idx_lo     = vpn[L2_W-1:0];
        if (sel_l2) begin
            base   = l2_base & PAGE_MASK;
            scaled = PA_W'(idx_lo) << SHIFT;
        end else begin
            base   = root_base & PAGE_MASK;
            scaled = PA_W'(idx_hi) << SHIFT;
        end
        entry_addr = base + scaled;
    end

endmodule

// File: rtl/ptw_pte_check.sv
// Entry checker: judges presence and, at the leaf level, access permission.
// Combinational; permission is only meaningful when is_leaf is high.
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [PTE_FLAG_W-1:0] flags,
    input  logic                  is_leaf,
    input  logic                  is_write,
    output logic                  present,
    output logic                  perm_ok
);

    // Decode the flag bits against the access type
    always_comb begin
        present = flags[PTE_VALID_BIT];
        if (!is_leaf) begin
            perm_ok = 1'b1;
        end else if (is_write) begin
            perm_ok = flags[PTE_WRITE_BIT];
        end else begin
            perm_ok = flags[PTE_READ_BIT];
        end
    end

endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker (top).
// Accepts one translation at a time, issues up to two table reads over a
// valid/ready port with single-beat responses, and returns a physical
// address or a fault classified by level and cause.
// Assumes each accepted memory read returns exactly one response beat.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned L1_W  = 10,
    parameter int unsigned L2_W  = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            root_wr_en,
    input  logic [PA_W-1:0] root_wr_data,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic            rsp_fault_level,
    output logic            rsp_fault_perm,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data
);

    localparam int unsigned VPN_W   = L1_W + L2_W;
    localparam int unsigned ENTRY_B = PA_W / 8;
    localparam logic [PA_W-1:0] FRAME_MASK = {{(PA_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

    walk_state_t     state_q;
    logic [VA_W-1:0] va_q;
    logic            write_q;
    logic [PA_W-1:0] l2_base_q;
    logic [PA_W-1:0] paddr_q;
    logic            fault_q;
    logic            level_q;
    logic            perm_q;

    logic            busy;
    logic            root_pending;
    logic [PA_W-1:0] root_base;
    logic            ent_present;
    logic            ent_perm_ok;
    logic            leaf_phase;

    assign busy       = (state_q != ST_IDLE);
    assign leaf_phase = (state_q == ST_L2_WAIT);

    ptw_root_reg #(
        .PA_W (PA_W)
    ) u_root (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (root_wr_en),
        .wr_data   (root_wr_data),
        .busy      (busy),
        .root_base (root_base),
        .pending   (root_pending)
    );

    ptw_addr_gen #(
        .PA_W    (PA_W),
        .L1_W    (L1_W),
        .L2_W    (L2_W),
        .OFF_W   (OFF_W),
        .ENTRY_B (ENTRY_B)
    ) u_addr (
        .vpn        (va_q[VA_W-1:OFF_W]),
        .root_base  (root_base),
        .l2_base    (l2_base_q),
        .sel_l2     (state_q == ST_L2_REQ),
        .entry_addr (mem_req_addr)
    );

    ptw_pte_check u_check (
        .flags    (mem_rsp_data[PTE_FLAG_W-1:0]),
        .is_leaf  (leaf_phase),
        .is_write (write_q),
        .present  (ent_present),
        .perm_ok  (ent_perm_ok)
    );

    // Walk sequencing: request, wait, classify, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (req_valid && req_ready) state_q <= ST_L1_REQ;
                ST_L1_REQ:  if (mem_req_ready) state_q <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) state_q <= ent_present ? ST_L2_REQ : ST_RESP;
                ST_L2_REQ:  if (mem_req_ready) state_q <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) state_q <= ST_RESP;
                ST_RESP:    state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            write_q <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid && req_ready) begin
            va_q    <= req_vaddr;
            write_q <= req_write;
        end
    end

    // Second-level table base from the first-level entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2_base_q <= '0;
        end else if (state_q == ST_L1_WAIT && mem_rsp_valid) begin
            l2_base_q <= mem_rsp_data & FRAME_MASK;
        end
    end

    // Result and fault classification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fault_q <= 1'b0;
            level_q <= 1'b0;
            perm_q  <= 1'b0;
        end else if (state_q == ST_L1_WAIT && mem_rsp_valid && !ent_present) begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            level_q <= 1'b0;
            perm_q  <= 1'b0;
        end else if (state_q == ST_L2_WAIT && mem_rsp_valid) begin
            level_q <= 1'b1;
            if (!ent_present) begin
                paddr_q <= '0;
                fault_q <= 1'b1;
                perm_q  <= 1'b0;
            end else if (!ent_perm_ok) begin
                paddr_q <= '0;
                fault_q <= 1'b1;
                perm_q  <= 1'b1;
            end else begin
                paddr_q <= (mem_rsp_data & FRAME_MASK) | PA_W'(va_q[OFF_W-1:0]);
                fault_q <= 1'b0;
                perm_q  <= 1'b0;
            end
        end
    end

    assign req_ready       = (state_q == ST_IDLE) && !root_pending;
    assign mem_req_valid   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign rsp_valid       = (state_q == ST_RESP);
    assign rsp_paddr       = paddr_q;
    assign rsp_fault       = fault_q;
    assign rsp_fault_level = level_q;
    assign rsp_fault_perm  = perm_q;

endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol and result checker for the page table walker, bound to the top.
// Assumes a well-behaved memory responder and a client that holds requests.
module ptw_walker_chk #(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic             rsp_fault_level,
    input logic             rsp_fault_perm,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr
);

    logic [OFF_W-1:0] off_cap_q;

    // Offset of the request currently being walked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cap_q <= '0;
        end else if (req_valid && req_ready) begin
            off_cap_q <= req_off;
        end
    end

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_busy_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_entry_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == off_cap_q);

    p_perm_leaf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault && rsp_fault_perm |-> rsp_fault_level);

    p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0);

endmodule

bind ptw_walker ptw_walker_chk #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_off         (req_vaddr[OFF_W-1:0]),
    .rsp_valid       (rsp_valid),
    .rsp_paddr       (rsp_paddr),
    .rsp_fault       (rsp_fault),
    .rsp_fault_level (rsp_fault_level),
    .rsp_fault_perm  (rsp_fault_perm),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0;
    logic [31:0] root_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_level;
    logic        rsp_fault_perm;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int checks = 0;
    int failures = 0;
    int n_ok = 0, n_l1inv = 0, n_l2inv = 0, n_perm = 0;
    logic [31:0] root_model = '0;

    always #2.5 clk = ~clk;

    ptw_walker u_dut (.*);

    // Memory model: table contents are a fixed arithmetic function of the address
    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [19:0] fr;
        logic [2:0]  fl;
        fr = (a[31:12] ^ 20'h5A3C1) + {8'h00, a[11:0]};
        fl = a[4:2] ^ a[14:12];
        return {fr, a[10:2], fl};
    endfunction

    logic [7:0]  tick;
    logic        mm_busy;
    logic [1:0]  mm_cnt;
    logic [31:0] mm_addr;

    // Responder with varying ready and latency, one beat per accepted read
    always @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0; mm_busy <= 1'b0; mm_cnt <= '0; mm_addr <= '0;
            mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
        end else begin
            tick <= tick + 8'd1;
            mem_req_ready <= (tick[2:0] != 3'd3) && (tick[2:0] != 3'd6);
            mem_rsp_valid <= 1'b0;
            if (mm_busy) begin
                if (mm_cnt == 2'd0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= pte_of(mm_addr);
                    mm_busy       <= 1'b0;
                end else begin
                    mm_cnt <= mm_cnt - 2'd1;
                end
            end else if (mem_req_valid && mem_req_ready) begin
                mm_busy <= 1'b1;
                mm_cnt  <= tick[4:3];
                mm_addr <= mem_req_addr;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_root(input logic [31:0] v);
        @(negedge clk);
        root_wr_en = 1'b1; root_wr_data = v;
        @(negedge clk);
        root_wr_en = 1'b0;
        root_model = v;
    endtask

    // One walk; optionally writes two root values mid-walk (deferred)
    task automatic walk(input logic [31:0] va, input bit wr, input bit defer,
                        input logic [31:0] rb, input logic [31:0] rc);
        logic [31:0] l1a, l2a, p1, p2, exp_pa, seen0, seen1;
        bit exp_f, exp_lvl, exp_perm, busy_bad, timeout;
        int n, wcnt, guard;
        l1a = {root_model[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
        p1  = pte_of(l1a);
        l2a = {p1[31:12], va[21:12], 2'b00};
        p2  = pte_of(l2a);
        exp_pa = '0; exp_f = 1'b1; exp_lvl = 1'b0; exp_perm = 1'b0;
        if (!p1[0]) begin
            n_l1inv++;
        end else if (!p2[0]) begin
            exp_lvl = 1'b1; n_l2inv++;
        end else if (!(wr ? p2[2] : p2[1])) begin
            exp_lvl = 1'b1; exp_perm = 1'b1; n_perm++;
        end else begin
            exp_f = 1'b0; exp_pa = {p2[31:12], va[11:0]}; n_ok++;
        end
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; wcnt = 0; busy_bad = 1'b0; timeout = 1'b0; guard = 0;
        seen0 = '0; seen1 = '0;
        forever begin
            root_wr_en = 1'b0;
            if (defer && n >= 1 && wcnt < 2) begin
                root_wr_en = 1'b1;
                root_wr_data = (wcnt == 0) ? rb : rc;
                wcnt++;
            end
            if (rsp_valid) break;
            if (req_ready) busy_bad = 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                if (n == 0) seen0 = mem_req_addr; else seen1 = mem_req_addr;
                n++;
            end
            guard++;
            if (guard > 300) begin timeout = 1'b1; break; end
            @(negedge clk);
        end
        root_wr_en = 1'b0;
        check(!timeout, "R9", "response arrives", 32'(timeout), 32'd0);
        check(!busy_bad, "R4", "req_ready low during walk", 32'(busy_bad), 32'd0);
        check(seen0 == l1a, "R2", "first read address", seen0, l1a);
        if (p1[0]) begin
            check(n == 2, "R3", "two reads", 32'(n), 32'd2);
            check(seen1 == l2a, "R3", "second read address", seen1, l2a);
        end else begin
            check(n == 1, "R6", "single read on L1 invalid", 32'(n), 32'd1);
        end
        check(rsp_fault == exp_f, exp_f ? (exp_lvl ? "R7" : "R6") : "R5", "fault flag",
              32'(rsp_fault), 32'(exp_f));
        if (exp_f) begin
            check(rsp_fault_level == exp_lvl, exp_lvl ? "R7" : "R6", "fault level",
                  32'(rsp_fault_level), 32'(exp_lvl));
            check(rsp_fault_perm == exp_perm, "R8", "fault cause",
                  32'(rsp_fault_perm), 32'(exp_perm));
            check(rsp_paddr == 32'h0, "R11", "paddr zero on fault", rsp_paddr, 32'h0);
        end else begin
            check(rsp_paddr == exp_pa, "R5", "physical address", rsp_paddr, exp_pa);
        end
        @(negedge clk);
        check(!rsp_valid, "R9", "response one cycle", 32'(rsp_valid), 32'd0);
        if (defer) begin
            check(!req_ready, "R10", "ready low while root applied", 32'(req_ready), 32'd0);
            root_model = rc;
        end else begin
            check(req_ready, "R9", "ready returns", 32'(req_ready), 32'd1);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "R9", "watchdog expired", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "reset req_ready", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);

        // Sweep: two roots (nonzero low bits ignored, R2), indices, access types
        for (int r = 0; r < 2; r++) begin
            set_root(r == 0 ? 32'h0004_0ABC : 32'h8123_4FFF);
            for (int i1 = 0; i1 < 8; i1++) begin
                for (int i2 = 0; i2 < 8; i2++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [9:0]  x1, x2;
                        logic [11:0] off;
                        x1  = 10'(i1 * 129 + r * 512);
                        x2  = 10'(i2 * 257 + i1);
                        off = 12'(i1 * i2 * 73 + w * 5 + r * 2049);
                        walk({x1, x2, off}, w[0], 1'b0, '0, '0);
                    end
                end
            end
        end

        // R10: root writes during a walk are deferred; the last one wins
        set_root(32'h0010_0000);
        walk(32'h0040_1234, 1'b0, 1'b1, 32'h0055_5000, 32'h0077_7000);
        walk(32'h0040_1234, 1'b0, 1'b0, '0, '0);
        walk(32'h0C80_3ABC, 1'b1, 1'b0, '0, '0);
        // R10: an idle write takes effect on the very next walk
        set_root(32'h0123_0000);
        walk(32'h0040_1234, 1'b1, 1'b0, '0, '0);

        check(n_ok > 0, "R5", "successful walks seen", 32'(n_ok), 32'd1);
        check(n_l1inv > 0, "R6", "first-level invalid seen", 32'(n_l1inv), 32'd1);
        check(n_l2inv > 0, "R7", "second-level invalid seen", 32'(n_l2inv), 32'd1);
        check(n_perm > 0, "R8", "permission faults seen", 32'(n_perm), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule